// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

This block watches a small set of asynchronous capture pins. Each pin passes through a two-flop synchronizer and an edge detector. When an enabled edge arrives, the unit copies the count value supplied by a neighbouring timer into that channel's capture register. Each channel chooses, through a packed control word, whether rising edges, falling edges or both trigger a capture. It also chooses whether a capture raises that channel's status flag, which feeds the interrupt line.

The block also chooses the count source for the shared counter. In timer mode the count-enable tick is asserted on every cycle, so the timer's prescaler sees the plain clock. In counter mode the tick pulses once for each enabled edge on one chosen capture channel, and the prescaler then divides those pulses. All configuration and status goes through a simple word-addressed register port with a combinational read path.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset:
  - all capture registers, the control word, the mode word and the flags read zero;
  - the unit is in timer mode (tick high);
  - irq_o is low.
- R2: Rising-edge enable is control-word bit 3*ch.
  - With it set, a rising pin change set up before clock edge k makes the capture register take the count_i value present at clock edge k+2.
- R3: Falling-edge enable is control-word bit 3*ch+1.
  - With it set, a falling pin change is captured with the same latency as R2.
- R4: Both enable bits set captures on either edge.
  - Both clear means no capture, and the register keeps its value.
  - An edge of the disabled polarity also leaves the register unchanged.
- R5: Interrupt enable is control-word bit 3*ch+2.
  - A capture sets the channel's flag only when this bit is set. An edge that is not captured never sets it.
  - The flags read at address 2, bit 4+ch. Bits 3:0 read zero.
  - irq_o is high when any flag is set.
- R6: Writing address 2 clears each flag whose bit 4+ch is 1. A 0 in that bit leaves the flag unchanged.
- R7: Capture registers sit at address 4+ch and can be written.
  - When a capture and a write to the same register fall on the same clock edge, the captured count is stored.
- R8: Address 1 holds the mode word: bit 0 = 1 selects counter mode, and bits 2:1 select the source channel.
  - In counter mode cnt_tick_o is high for exactly one cycle per enabled edge of the source channel.
  - That cycle is the one that ends with the capture edge.
- R9: In timer mode cnt_tick_o is high on every cycle, and the channel-select field is ignored.
- R10: In counter mode, edges on channels other than the selected one never raise cnt_tick_o, even when those channels capture.

Control-word bits are as stated in R2, R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (3) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| cap_pin_i | input | NCH (4) | Asynchronous capture pins |
| count_i | input | CW (32) | Current count from the timer |
| cnt_tick_o | output | 1 | Count-enable tick to the timer's prescaler |
| irq_o | output | 1 | OR of all capture flags |

## Verification
The bound checker checks on every cycle that:
- a detected capture event stores the count from the previous edge;
- a channel with both edge enables clear never produces an event;
- a flag only rises after an event on a channel whose interrupt enable is set;
- the tick stays high in timer mode and in counter mode needs an edge behind it.

Only the bench's scenarios can show the properties that depend on timing or ordering:
- the exact two-to-three clock latency from the pin to the stored value;
- the polarity choices;
- write-one-to-clear against write-zero;
- capture winning over a colliding register write;
- the tick being restricted to the selected channel.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  typedef enum logic {
    SRC_TIMER   = 1'b0,
    SRC_COUNTER = 1'b1
  } cnt_src_e;

  localparam int DW       = 32;
  localparam int FLAG_OFS = 4;
  localparam int CAP_BASE = 4;
  localparam int A_CTL    = 0;
  localparam int A_MODE   = 1;
  localparam int A_FLAG   = 2;

  // True when an enabled polarity matches the detected transition.
  function automatic logic edge_hit(input logic rise_en, input logic fall_en,
                                    input logic rose, input logic fell);
    return (rise_en & rose) | (fall_en & fell);
  endfunction

endpackage

// File: rtl/ecu_sync_edge.sv
module ecu_sync_edge #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] rose_o,
  output logic [NCH-1:0] fell_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[c];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rose_o[c] = sync_q & ~prev_q;
    assign fell_o[c] = ~sync_q & prev_q;
  end

endmodule

// File: rtl/ecu_chan.sv
module ecu_chan #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          irq_en_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wval_i,
  input  logic          clr_i,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] cap_o,
  output logic          flag_o
);

  // Capture has priority over a software write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_o <= '0;
    else if (hit_i) cap_o <= count_i;
    else if (wr_i)  cap_o <= wval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_o <= 1'b0;
    else if (hit_i && irq_en_i) flag_o <= 1'b1;
    else if (clr_i)             flag_o <= 1'b0;
  end

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  localparam int AW    = $clog2(CAP_BASE + NCH),
  localparam int CSELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic [NCH-1:0] cap_pin_i,
  input  logic [CW-1:0]  count_i,
  output logic           cnt_tick_o,
  output logic           irq_o
);

  localparam int CTLW = 3 * NCH;

  logic [CTLW-1:0]   ctl_q;
  cnt_src_e          mode_q;
  logic [CSELW-1:0]  sel_q;
  logic [NCH-1:0]    rose, fell;
  logic [NCH-1:0]    cap_hit;
  logic [NCH-1:0]    flag_q;
  logic [NCH-1:0]    flag_clr;
  logic [NCH-1:0]    cap_wr;
  logic [NCH*CW-1:0] cap_flat;
  logic              sel_hit;

  logic wr_ctl, wr_mode, wr_flag;
  assign wr_ctl  = wr_en_i && (addr_i == AW'(A_CTL));
  assign wr_mode = wr_en_i && (addr_i == AW'(A_MODE));
  assign wr_flag = wr_en_i && (addr_i == AW'(A_FLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mode_q <= SRC_TIMER;
      sel_q  <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata_i[CTLW-1:0];
      if (wr_mode) begin
        mode_q <= cnt_src_e'(wdata_i[0]);
        sel_q  <= wdata_i[CSELW:1];
      end
    end
  end

  ecu_sync_edge #(.NCH(NCH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin_i),
    .rose_o (rose),
    .fell_o (fell)
  );

  assign flag_clr = wr_flag ? wdata_i[FLAG_OFS +: NCH] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign cap_hit[c] = edge_hit(ctl_q[3*c], ctl_q[3*c+1], rose[c], fell[c]);
    assign cap_wr[c]  = wr_en_i && (addr_i == AW'(CAP_BASE + c));

    ecu_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (cap_hit[c]),
      .irq_en_i (ctl_q[3*c+2]),
      .wr_i     (cap_wr[c]),
      .wval_i   (wdata_i[CW-1:0]),
      .clr_i    (flag_clr[c]),
      .count_i  (count_i),
      .cap_o    (cap_flat[c*CW +: CW]),
      .flag_o   (flag_q[c])
    );
  end

  always_comb begin
    sel_hit = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (sel_q == CSELW'(c)) sel_hit = cap_hit[c];
  end

  assign cnt_tick_o = (mode_q == SRC_COUNTER) ? sel_hit : 1'b1;
  assign irq_o      = |flag_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CTL)) begin
      rdata_o[CTLW-1:0] = ctl_q;
    end else if (addr_i == AW'(A_MODE)) begin
      rdata_o[0]       = mode_q;
      rdata_o[CSELW:1] = sel_q;
    end else if (addr_i == AW'(A_FLAG)) begin
      rdata_o[FLAG_OFS +: NCH] = flag_q;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (addr_i == AW'(CAP_BASE + c)) rdata_o[CW-1:0] = cap_flat[c*CW +: CW];
    end
  end

endmodule

// File: rtl/ecu_chk.sv
module ecu_chk #(
  parameter int NCH   = 4,
  parameter int CW    = 32,
  parameter int CSELW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    cap_hit,
  input logic [NCH-1:0]    rose,
  input logic [NCH-1:0]    fell,
  input logic [3*NCH-1:0]  ctl_q,
  input logic [NCH-1:0]    flag_q,
  input logic [NCH*CW-1:0] cap_flat,
  input logic [CW-1:0]     count_i,
  input logic              mode_q,
  input logic              cnt_tick_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r2_capture_stores_count: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[c] |=> cap_flat[c*CW +: CW] == $past(count_i));

    a_r4_disabled_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[3*c] && !ctl_q[3*c+1]) |-> !cap_hit[c]);

    a_r5_flag_needs_enabled_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[c]) |-> $past(cap_hit[c] && ctl_q[3*c+2]));
  end

  a_r9_timer_tick_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> cnt_tick_o);

  a_r8_tick_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && cnt_tick_o) |-> |(rose | fell));

endmodule

bind edge_capture_unit ecu_chk #(.NCH(NCH), .CW(CW), .CSELW(CSELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_hit    (cap_hit),
  .rose       (rose),
  .fell       (fell),
  .ctl_q      (ctl_q),
  .flag_q     (flag_q),
  .cap_flat   (cap_flat),
  .count_i    (count_i),
  .mode_q     (mode_q),
  .cnt_tick_o (cnt_tick_o)
);

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] pins = '0;
  logic [CW-1:0]  cnt = '0;
  logic           tick, irq;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  logic t0, t1, t2;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_unit #(.NCH(NCH), .CW(CW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .cap_pin_i  (pins),
    .count_i    (cnt),
    .cnt_tick_o (tick),
    .irq_o      (irq)
  );

  // {ch[1:0], level, ctl[2:0] = {irq_en, fall_en, rise_en}, exp_cap, exp_flag}
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 1'b1, 3'b001, 1'b1, 1'b0},
    {2'd1, 1'b0, 3'b010, 1'b1, 1'b0},
    {2'd2, 1'b1, 3'b011, 1'b1, 1'b0},
    {2'd2, 1'b0, 3'b011, 1'b1, 1'b0},
    {2'd3, 1'b1, 3'b000, 1'b0, 1'b0},
    {2'd3, 1'b0, 3'b101, 1'b0, 1'b0},
    {2'd0, 1'b0, 3'b110, 1'b1, 1'b1},
    {2'd1, 1'b1, 3'b101, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
  endtask

  // Pin change before edge k; capture lands at edge k+2 with count base+2.
  task automatic pulse(input int ch, input logic lvl, input logic [31:0] base,
                       input bit do_wr, input logic [31:0] wv);
    @(negedge clk);
    pins[ch] = lvl; cnt = base;
    @(negedge clk);
    t0 = tick; cnt = base + 1;
    @(negedge clk);
    t1 = tick; cnt = base + 2;
    if (do_wr) begin wr_en = 1'b1; addr = AW'(4 + ch); wdata = wv; end
    @(negedge clk);
    t2 = tick; wr_en = 1'b0; cnt = base + 3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      if (a != 3) begin rd(a, d); check("R1 reg reset", d, 32'h0); end
    end
    check("R1 tick", {31'd0, tick}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      int ch;
      logic lv, ec, ef;
      logic [2:0] ctl;
      logic [31:0] base;
      ch = int'(VEC[i][7:6]); lv = VEC[i][5]; ctl = VEC[i][4:2];
      ec = VEC[i][1]; ef = VEC[i][0];
      base = 32'h100 + 32'(i) * 32'h10;
      wr(0, 32'(ctl) << (3 * ch));
      @(negedge clk); pins[ch] = ~lv;
      repeat (4) @(negedge clk);
      wr(2, 32'hF0);
      rd(4 + ch, prev);
      pulse(ch, lv, base, 1'b0, 32'h0);
      rd(4 + ch, d);
      check(ec ? "R2/R3/R4 capture value" : "R4 no capture", d, ec ? base + 2 : prev);
      rd(2, d);
      check("R5 flag bit", {31'd0, d[4 + ch]}, {31'd0, ef});
      check("R5 low bits zero", {28'd0, d[3:0]}, 32'd0);
      check("R5 irq", {31'd0, irq}, {31'd0, ef});
    end

    // R6 write-one-to-clear (ch1 flag set by last vector)
    wr(2, 32'h0);
    rd(2, d);
    check("R6 zero write keeps flag", {31'd0, d[5]}, 32'd1);
    wr(2, 32'h20);
    rd(2, d);
    check("R6 one write clears flag", {31'd0, d[5]}, 32'd0);
    check("R6 irq low", {31'd0, irq}, 32'd0);

    // R7 register write and collision
    wr(0, 32'b001);
    pulse(0, 1'b1, 32'h500, 1'b1, 32'hDEAD);
    rd(4, d);
    check("R7 capture wins collision", d, 32'h502);
    wr(4, 32'h1234);
    rd(4, d);
    check("R7 plain write", d, 32'h1234);

    // R8 / R10 counter mode, source channel 2
    @(negedge clk); pins[1] = 1'b0; pins[2] = 1'b0;
    repeat (4) @(negedge clk);
    wr(1, 32'h5);
    rd(1, d);
    check("R8 mode readback", d, 32'h5);
    wr(0, (32'b001 << 6) | (32'b001 << 3));
    pulse(2, 1'b1, 32'h600, 1'b0, 32'h0);
    check("R8 tick before", {31'd0, t0}, 32'd0);
    check("R8 tick pulse", {31'd0, t1}, 32'd1);
    check("R8 tick after", {31'd0, t2}, 32'd0);
    pulse(1, 1'b1, 32'h700, 1'b0, 32'h0);
    check("R10 other channel no tick", {29'd0, t0, t1, t2}, 32'd0);
    rd(5, d);
    check("R10 other channel still captures", d, 32'h702);

    // R9 timer mode ignores select
    wr(1, 32'h4);
    wr(0, 32'b011 << 6);
    pulse(2, 1'b0, 32'h800, 1'b0, 32'h0);
    check("R9 tick always high", {29'd0, t0, t1, t2}, 32'd7);

    finish_run();
  end

endmodule